// File: doc/BRIEF.md
# Dual-Law Serial Clock Divider

This block derives the serial clock of a synchronous serial master from a faster module clock. A 13-bit control word picks one of two division laws. In the linear law the serial clock runs at the module clock divided by 2*(N+1), where N is an 8-bit field. In the exponential law it runs at the module clock divided by 2^M, where M is a 4-bit field. Because the module clock must be at least twice the serial clock, the smallest division is 2. With the exponential law and M = 0 the law would give division by 1, so the block forces division by 2 instead. The output always has a 50% duty cycle.

Control word layout: bits 7:0 hold N, bits 11:8 hold M, and bit 12 selects the law (1 = linear, 0 = exponential). Each serial clock level lasts H module-clock cycles, called the half period. The linear law gives H = N+1. The exponential law gives H = 2^(M-1), or H = 1 when M = 0.

Besides the serial clock level, the block gives the shift engine three single-cycle pulses: a leading-edge strobe on each rising edge, a trailing-edge strobe on each falling edge, and a toggle pulse on every edge. The block reads the control word only at a period boundary, so a mid-period change never shortens a level.

The sequencer has three states:
- ST_IDLE: the clock is parked low.
- ST_LOW: the first half of a period, with the clock low.
- ST_HIGH: the second half of a period, with the clock high.

Its transitions are:
- start (ST_IDLE to ST_LOW): taken when the enable is seen high. The divider is loaded.
- lead (ST_LOW to ST_HIGH): taken after H cycles. The clock rises.
- wrap (ST_HIGH to ST_LOW): taken after H cycles while the enable is still high. The clock falls and the divider is reloaded.
- park (ST_HIGH to ST_IDLE): taken after H cycles once the enable is low. The clock falls.

Top module: `dual_law_clkdiv`

## Requirements
- R1: Out of reset, sclk, sclk_toggle, lead_stb and trail_stb are all 0.
- R2: With bit 12 = 1, the serial clock period is 2*(N+1) module-clock cycles, taking N from bits 7:0. Bits 11:8 have no effect.
- R3: With bit 12 = 0 and M in bits 11:8 from 1 to 15, the period is 2^M cycles. Bits 7:0 have no effect.
- R4: With bit 12 = 0 and M = 0, the period is 2 cycles (the clock toggles every cycle).
- R5: When run_en is first seen high at a rising edge, sclk stays low and the first rising edge of sclk comes H cycles after that edge.
- R6: lead_stb is high for exactly one cycle, in the cycle where sclk has just risen. trail_stb is high for exactly one cycle, in the cycle where sclk has just fallen. sclk_toggle is high in both of those cycles and in no other.
- R7: sclk is high for H cycles and low for H cycles in every period (50% duty).
- R8: A change to div_ctrl made while the clock is high leaves the current high level at the old H. The new H applies from the following low level on.
- R9: Dropping run_en mid-period lets the current period finish with its full high level and trailing edge. After that, sclk stays low and no strobe occurs.
- R10: With bit 12 = 1 and N = 255, the division is the largest, 512 (H = 256).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Keep generating serial clock periods while high |
| div_ctrl | input | 13 | Divider control word: N in 7:0, M in 11:8, law select in 12 |
| sclk | output | 1 | Serial clock level, idles low |
| sclk_toggle | output | 1 | One-cycle pulse on every sclk edge |
| lead_stb | output | 1 | One-cycle pulse on each rising sclk edge |
| trail_stb | output | 1 | One-cycle pulse on each falling sclk edge |

## Verification
All outputs are registered, so each edge becomes visible in the cycle after the rising edge that ends a count. The bench drives inputs at falling edges and samples at falling edges. If run_en is raised at one falling edge, the first lead_stb must appear at exactly the (H+1)-th falling edge after it. From then on, each level must hold for exactly H samples. The trailing strobe is checked in the first low sample, and the next leading strobe in the first high sample after the low level. For the divider change and the shutdown cases, the bench makes the change in the sample where lead_stb is seen. It then counts the remaining high samples against the old H, and the later levels against the new H, or checks that the clock stays parked low.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } div_state_t;
endpackage

// File: rtl/clkdiv_law_decode.sv
`timescale 1ns/1ps
// Turns the control word into a half period, in module-clock cycles.
module clkdiv_law_decode #(
    parameter int N_W    = 8,
    parameter int M_W    = 4,
    parameter int HALF_W = 15
) (
    input  logic [N_W+M_W:0]  ctrl,
    output logic [HALF_W-1:0] half
);
    localparam int SEL_BIT = N_W + M_W;

    logic [N_W-1:0] n_field;
    logic [M_W-1:0] m_field;
    logic           lin_sel;

    assign n_field = ctrl[N_W-1:0];
    assign m_field = ctrl[N_W+M_W-1:N_W];
    assign lin_sel = ctrl[SEL_BIT];

    always_comb begin
        if (lin_sel) begin
            half = HALF_W'(n_field) + HALF_W'(1);
        end else if (m_field == '0) begin
            // exponent zero would mean divide by one: clamp to divide by two
            half = HALF_W'(1);
        end else begin
            half = HALF_W'(1) << (m_field - M_W'(1));
        end
    end
endmodule

// File: rtl/clkdiv_half_counter.sv
`timescale 1ns/1ps
// Counts out one half period; done is high in its last cycle.
module clkdiv_half_counter #(
    parameter int HALF_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [HALF_W-1:0] limit,
    output logic              done
);
    logic [HALF_W-1:0] cnt;

    assign done = run && (cnt == (limit - HALF_W'(1)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || done) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + HALF_W'(1);
        end
    end
endmodule

// File: rtl/dual_law_clkdiv.sv
`timescale 1ns/1ps
module dual_law_clkdiv #(
    parameter int N_W = 8,
    parameter int M_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [N_W+M_W:0] div_ctrl,
    output logic             sclk,
    output logic             sclk_toggle,
    output logic             lead_stb,
    output logic             trail_stb
);
    import clkdiv_pkg::*;

    localparam int LIN_HALF_W = N_W + 1;
    localparam int EXP_HALF_W = (1 << M_W) - 1;
    localparam int HALF_W     = (LIN_HALF_W > EXP_HALF_W) ? LIN_HALF_W : EXP_HALF_W;

    div_state_t        state_q, state_d;
    logic [HALF_W-1:0] half_dec;
    logic [HALF_W-1:0] half_q;
    logic              half_done;
    logic              load_half;
    logic              rise_now;
    logic              fall_now;

    clkdiv_law_decode #(
        .N_W    (N_W),
        .M_W    (M_W),
        .HALF_W (HALF_W)
    ) u_decode (
        .ctrl (div_ctrl),
        .half (half_dec)
    );

    clkdiv_half_counter #(
        .HALF_W (HALF_W)
    ) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q != ST_IDLE),
        .limit (half_q),
        .done  (half_done)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (run_en)    state_d = ST_LOW;
            ST_LOW:  if (half_done) state_d = ST_HIGH;
            ST_HIGH: if (half_done) state_d = run_en ? ST_LOW : ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    assign rise_now  = (state_q == ST_LOW)  && half_done;
    assign fall_now  = (state_q == ST_HIGH) && half_done;
    // the divider is reloaded only at a period boundary
    assign load_half = (state_q == ST_IDLE) || fall_now;

    // state register and divider latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            half_q  <= HALF_W'(1);
        end else begin
            state_q <= state_d;
            if (load_half) begin
                half_q <= half_dec;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk        <= 1'b0;
            sclk_toggle <= 1'b0;
            lead_stb    <= 1'b0;
            trail_stb   <= 1'b0;
        end else begin
            lead_stb    <= rise_now;
            trail_stb   <= fall_now;
            sclk_toggle <= rise_now || fall_now;
            if (rise_now) begin
                sclk <= 1'b1;
            end else if (fall_now) begin
                sclk <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/clkdiv_chk.sv
`timescale 1ns/1ps
module clkdiv_chk (
    input logic clk,
    input logic rst_n,
    input logic sclk,
    input logic sclk_toggle,
    input logic lead_stb,
    input logic trail_stb
);
    // R6
    lead_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> lead_stb);

    // R6
    trail_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> trail_stb);

    // R6
    lead_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lead_stb |=> !lead_stb);

    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lead_stb, trail_stb}));

    // R7
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_toggle |-> $stable(sclk));

    // R6
    lead_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lead_stb |-> sclk);
endmodule

bind dual_law_clkdiv clkdiv_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk        (sclk),
    .sclk_toggle (sclk_toggle),
    .lead_stb    (lead_stb),
    .trail_stb   (trail_stb)
);

// File: tb/sim_dual_law_clkdiv.sv
`timescale 1ns/1ps
module sim_dual_law_clkdiv;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic [12:0] div_ctrl = '0;
    logic        sclk, sclk_toggle, lead_stb, trail_stb;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    dual_law_clkdiv u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_en      (run_en),
        .div_ctrl    (div_ctrl),
        .sclk        (sclk),
        .sclk_toggle (sclk_toggle),
        .lead_stb    (lead_stb),
        .trail_stb   (trail_stb)
    );

    function automatic int exp_half(input logic [12:0] c);
        if (c[12])            return int'(c[7:0]) + 1;
        else if (c[11:8] == 0) return 1;
        else                  return 1 << (int'(c[11:8]) - 1);
    endfunction

    task automatic check(input string req, input int act, input int expv);
        tests++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic count_level(input logic lvl, output int n);
        n = 0;
        while (sclk == lvl && n < 100000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_lead(input int limit, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!lead_stb && n < limit);
    endtask

    task automatic stop_run(input int h);
        run_en = 1'b0;
        repeat (2 * h + 4) @(negedge clk);
    endtask

    // one full period from a cold start, with start latency, duty and strobes
    task automatic run_case(input string req, input logic [12:0] cfg);
        int h, n;
        h = exp_half(cfg);
        div_ctrl = cfg;
        @(negedge clk);
        run_en = 1'b1;
        wait_lead(3 * h + 10, n);
        check({req, " R5 first lead latency"}, n, h + 1);
        check({req, " R6 lead sample sclk/toggle"}, {30'd0, sclk, sclk_toggle}, 3);
        count_level(1'b1, n);
        check({req, " R7 high length"}, n, h);
        check({req, " R6 trail sample strobe/toggle"}, {30'd0, trail_stb, sclk_toggle}, 3);
        count_level(1'b0, n);
        check({req, " R7 low length"}, n, h);
        check({req, " R6 next lead strobe"}, {31'd0, lead_stb}, 1);
        stop_run(h);
    endtask

    task automatic change_case();
        int n;
        div_ctrl = 13'h1002;          // linear, N=2, H=3
        @(negedge clk);
        run_en = 1'b1;
        wait_lead(40, n);
        div_ctrl = 13'h1005;          // linear, N=5, H=6
        count_level(1'b1, n);
        check("R8 high level keeps old divider", n, 3);
        count_level(1'b0, n);
        check("R8 next low uses new divider", n, 6);
        count_level(1'b1, n);
        check("R8 next high uses new divider", n, 6);
        stop_run(6);
    endtask

    task automatic shutdown_case();
        int n, act;
        div_ctrl = 13'h1002;          // H=3
        @(negedge clk);
        run_en = 1'b1;
        wait_lead(40, n);
        run_en = 1'b0;
        count_level(1'b1, n);
        check("R9 high level completes after disable", n, 3);
        check("R9 trailing strobe after disable", {31'd0, trail_stb}, 1);
        act = 0;
        repeat (20) begin
            @(negedge clk);
            act += int'(sclk) + int'(lead_stb) + int'(trail_stb) + int'(sclk_toggle);
        end
        check("R9 parked low with no strobes", act, 0);
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset sclk", {31'd0, sclk}, 0);
        check("R1 reset strobes", {29'd0, sclk_toggle, lead_stb, trail_stb}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 idle after reset", {28'd0, sclk, sclk_toggle, lead_stb, trail_stb}, 0);

        run_case("R2 linear N=4 M ignored", 13'h1704);
        run_case("R2 linear N=0", 13'h1000);
        run_case("R3 exp M=3 N ignored", 13'h03AB);
        run_case("R3 exp M=1", 13'h0100);
        run_case("R4 exp M=0 clamp", 13'h0010);
        run_case("R10 linear N=255", 13'h10FF);
        run_case("R3 exp M=15", 13'h0F00);
        change_case();
        shutdown_case();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule